// File: doc/BRIEF.md
# Fractional-Rate Realtime Count Source

This block produces a free-running 64-bit count that advances at a fixed average rate of 6.144 MHz. It does this whatever reference clock drives it, provided the reference is one of the supported frequencies. Each reference edge adds a 12-bit step value to an accumulator. When the accumulator reaches a 12-bit modulus, the modulus is subtracted and the count moves on by one. The step-to-modulus ratio is therefore the fraction of reference edges that produce a count, and it is chosen per reference frequency. For example, 12.0 MHz with step 1664 and modulus 3250 gives exactly 6.144 MHz.

A small register port holds a pending step and a pending modulus. A commit request bit copies them into the active incrementer, so the new ratio applies at a defined edge and the accumulator residue carries over. At reset, a 3-bit reference-select input picks a default ratio from a built-in table. The count is visible on a port for consumers, and it can also be read as two 32-bit words. Reading the low word captures the high word, so a two-word read is coherent.

Top module: `rtc_frac_counter`

## Requirements
- R1: While `rst` is high at a clock edge, the count and accumulator clear to zero. Both the active ratio and the pending registers load the table ratio for the current `clk_sel`. The pending step then reads at offset 0x10 and the pending modulus at offset 0x14, each with upper bits zero.
- R2: The default table for `clk_sel` is as follows: 1 gives 1664/3250, 2 gives 1536/3250, 4 gives 1040/3250, 5 gives 768/3250, 6 gives 768/3375 and 7 gives 520/3250. Codes 0 and 3 give 0/0. From reset with a fixed ratio step/modulus, the count after N reference edges equals floor(N*step/modulus).
- R3: While the active modulus is zero, the count and accumulator hold their values.
- R4: On each edge with a nonzero active modulus, the accumulator becomes accumulator plus step. If that sum is at least the modulus, the modulus is subtracted and the count increments by exactly one. The count never moves by more than one per edge. A step equal to the modulus advances the count on every edge. The supported range is step ≤ modulus.
- R5: A write to offset 0x10 stores all 32 bits, and bits [11:0] form the step. A write to offset 0x14 stores all bits except bit 16, and bits [11:0] form the modulus. Upper bits read back exactly as written.
- R6: Writes to the pending step or modulus do not change the count rate until a commit.
- R7: A write to offset 0x14 with bit 16 set is a commit request. The active ratio takes the pending values at the first edge after the write edge. Counting with the new ratio begins at the edge after that. The accumulator residue is kept, not cleared.
- R8: Bit 16 of offset 0x14 reads 1 from the write edge of a commit request until the commit edge, and reads 0 afterwards.
- R9: No register access clears or alters the count. Writes to offsets 0x00 and 0x04 are ignored. A change of `clk_sel` outside reset does not change the active ratio.
- R10: Reading offset 0x00 returns bits [31:0] of the live count. A read strobe at 0x00 captures bits [63:32] at that edge, and offset 0x04 returns that captured word, which is zero after reset. Other offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, any supported frequency |
| rst | input | 1 | Synchronous active-high reset |
| clk_sel | input | 3 | Reference-select code choosing the reset-time default ratio |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (captures the high word on a low-word read) |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| count_o | output | 64 | Live free-running count |

## Verification
The bench runs every reference-select code from reset for a fixed number of edges and compares the count with floor(N*step/modulus). A wrong table entry or a truncating accumulator would miss by at least one. It also checks the count edge by edge across a commit. A design that applied the ratio one edge early or late, or that cleared the residue, would drift from the expected sequence. It drives a zero modulus, which must freeze the count rather than run away, and a step equal to the modulus, which must count on every edge. It also verifies that upper register bits survive, that the commit bit clears itself, and that count-register writes and reference-select changes are ignored.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int RATIO_W  = 12;
    localparam int ACC_W    = RATIO_W + 1;
    localparam int CNT_W    = 64;
    localparam int HALF_W   = CNT_W / 2;
    localparam int SEL_W    = 3;
    localparam int ADDR_W   = 5;
    localparam int DATA_W   = 32;
    localparam int COMMIT_BIT = 16;

    localparam logic [ADDR_W-1:0] OFS_CNT_LO = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_CNT_HI = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_STEP   = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_MOD    = 5'h14;

    typedef struct packed {
        logic [RATIO_W-1:0] step;
        logic [RATIO_W-1:0] modulus;
    } ratio_t;

    function automatic ratio_t default_ratio(input logic [SEL_W-1:0] sel);
        ratio_t r;
        case (sel)
            3'd1:    r = '{step: 12'd1664, modulus: 12'd3250};
            3'd2:    r = '{step: 12'd1536, modulus: 12'd3250};
            3'd4:    r = '{step: 12'd1040, modulus: 12'd3250};
            3'd5:    r = '{step: 12'd768,  modulus: 12'd3250};
            3'd6:    r = '{step: 12'd768,  modulus: 12'd3375};
            3'd7:    r = '{step: 12'd520,  modulus: 12'd3250};
            default: r = '{step: 12'd0,    modulus: 12'd0};
        endcase
        return r;
    endfunction
endpackage

// File: rtl/rtc_ratio_regs.sv
module rtc_ratio_regs
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  clk_sel,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] step_reg,
    output logic [DATA_W-1:0] mod_reg,
    output ratio_t            active
);
    localparam logic [DATA_W-1:0] COMMIT_MASK = DATA_W'(1) << COMMIT_BIT;

    logic [DATA_W-1:0] step_q;
    logic [DATA_W-1:0] mod_q;
    logic              commit_q;
    ratio_t            active_q;
    ratio_t            dflt;
    logic              wr_step;
    logic              wr_mod;

    always_comb begin
        dflt    = default_ratio(clk_sel);
        wr_step = wr_en && (addr == OFS_STEP);
        wr_mod  = wr_en && (addr == OFS_MOD);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q   <= DATA_W'(dflt.step);
            mod_q    <= DATA_W'(dflt.modulus);
            commit_q <= 1'b0;
            active_q <= dflt;
        end else begin
            if (commit_q) begin
                active_q <= '{step: step_q[RATIO_W-1:0], modulus: mod_q[RATIO_W-1:0]};
            end
            commit_q <= wr_mod && wdata[COMMIT_BIT];
            if (wr_step) begin
                step_q <= wdata;
            end
            if (wr_mod) begin
                mod_q <= wdata & ~COMMIT_MASK;
            end
        end
    end

    assign step_reg = step_q;
    assign mod_reg  = mod_q | (commit_q ? COMMIT_MASK : '0);
    assign active   = active_q;

    // R8: a commit request clears itself unless renewed
    p_commit_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (commit_q && !(wr_mod && wdata[COMMIT_BIT])) |=> !commit_q);

    // R7: the commit edge copies the pending fields into the active ratio
    p_commit_loads_r7: assert property (@(posedge clk) disable iff (rst)
        commit_q |=> (active_q.step == $past(step_q[RATIO_W-1:0]) &&
                      active_q.modulus == $past(mod_q[RATIO_W-1:0])));

    // R6 / R9: without a commit the active ratio is left alone
    p_active_stable_r6: assert property (@(posedge clk) disable iff (rst)
        !commit_q |=> $stable(active_q));
endmodule

// File: rtl/rtc_frac_incr.sv
module rtc_frac_incr
    import rtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  ratio_t           ratio,
    output logic [CNT_W-1:0] cnt_o
);
    logic [ACC_W-1:0] acc_q;
    logic [CNT_W-1:0] cnt_q;
    logic [ACC_W:0]   sum;
    logic [ACC_W:0]   wrapped;
    logic             live;
    logic             hit;

    always_comb begin
        live    = (ratio.modulus != '0);
        sum     = {1'b0, acc_q} + (ACC_W+1)'(ratio.step);
        wrapped = sum - (ACC_W+1)'(ratio.modulus);
        hit     = live && (sum >= (ACC_W+1)'(ratio.modulus));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (live) begin
            if (hit) begin
                acc_q <= wrapped[ACC_W-1:0];
                cnt_q <= cnt_q + 1'b1;
            end else begin
                acc_q <= sum[ACC_W-1:0];
            end
        end
    end

    assign cnt_o = cnt_q;

    // R3: zero modulus freezes the count
    p_hold_zero_mod_r3: assert property (@(posedge clk) disable iff (rst)
        !live |=> $stable(cnt_q));

    // R4: at most one count per reference edge
    p_single_step_r4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));

    // R4: step equal to modulus counts every edge
    p_full_rate_r4: assert property (@(posedge clk) disable iff (rst)
        (live && ratio.step == ratio.modulus) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/rtc_read_port.sv
module rtc_read_port
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [DATA_W-1:0] step_reg,
    input  logic [DATA_W-1:0] mod_reg,
    output logic [DATA_W-1:0] rdata
);
    logic [HALF_W-1:0] hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= '0;
        end else if (rd_en && addr == OFS_CNT_LO) begin
            hi_q <= cnt[CNT_W-1:HALF_W];
        end
    end

    always_comb begin
        case (addr)
            OFS_CNT_LO: rdata = DATA_W'(cnt[HALF_W-1:0]);
            OFS_CNT_HI: rdata = DATA_W'(hi_q);
            OFS_STEP:   rdata = step_reg;
            OFS_MOD:    rdata = mod_reg;
            default:    rdata = '0;
        endcase
    end

    // R10: a low-word read captures the high word of that same edge
    p_hi_capture_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == OFS_CNT_LO) |=> hi_q == $past(cnt[CNT_W-1:HALF_W]));

    // R10: the captured word only moves on a low-word read
    p_hi_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !(rd_en && addr == OFS_CNT_LO) |=> $stable(hi_q));
endmodule

// File: rtl/rtc_frac_counter.sv
module rtc_frac_counter
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  clk_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [CNT_W-1:0]  count_o
);
    logic [DATA_W-1:0] step_reg;
    logic [DATA_W-1:0] mod_reg;
    ratio_t            active;
    logic [CNT_W-1:0]  cnt;

    rtc_ratio_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .clk_sel  (clk_sel),
        .wr_en    (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .step_reg (step_reg),
        .mod_reg  (mod_reg),
        .active   (active)
    );

    rtc_frac_incr u_incr (
        .clk   (clk),
        .rst   (rst),
        .ratio (active),
        .cnt_o (cnt)
    );

    rtc_read_port u_rd (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (reg_rd),
        .addr     (reg_addr),
        .cnt      (cnt),
        .step_reg (step_reg),
        .mod_reg  (mod_reg),
        .rdata    (reg_rdata)
    );

    assign count_o = cnt;

    // R9: register accesses never pull the count backwards
    p_no_clear_r9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> count_o >= $past(count_o));
endmodule

// File: tb/rtc_frac_counter_tb.sv
module rtc_frac_counter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int RUN_N = 200;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  clk_sel = 3'd0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [4:0]  reg_addr = 5'h0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic [63:0] count_o;

    int checks = 0;
    int errors = 0;

    // model state
    longint m_cnt;
    int     m_acc, m_as, m_am, m_ps, m_pm;
    bit     m_commit;

    // {sel, expected count after RUN_N edges, step, modulus}
    localparam logic [42:0] VEC [8] = '{
        {3'd0, 16'd0,   12'd0,    12'd0},
        {3'd1, 16'd102, 12'd1664, 12'd3250},
        {3'd2, 16'd94,  12'd1536, 12'd3250},
        {3'd3, 16'd0,   12'd0,    12'd0},
        {3'd4, 16'd64,  12'd1040, 12'd3250},
        {3'd5, 16'd47,  12'd768,  12'd3250},
        {3'd6, 16'd45,  12'd768,  12'd3375},
        {3'd7, 16'd32,  12'd520,  12'd3250}
    };

    rtc_frac_counter u_dut (
        .clk       (clk),
        .rst       (rst),
        .clk_sel   (clk_sel),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .count_o   (count_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // one edge with given inputs; model tracks the requirement rules
    task automatic cyc(input bit wr, input logic [4:0] a, input logic [31:0] d, input bit rd);
        int s;
        reg_wr = wr; reg_addr = a; reg_wdata = d; reg_rd = rd;
        @(posedge clk);
        if (m_am != 0) begin
            s = m_acc + m_as;
            if (s >= m_am) begin m_acc = s - m_am; m_cnt++; end
            else m_acc = s;
        end
        if (m_commit) begin m_as = m_ps; m_am = m_pm; end
        m_commit = wr && a == 5'h14 && d[16];
        if (wr && a == 5'h10) m_ps = int'(d[11:0]);
        if (wr && a == 5'h14) m_pm = int'(d[11:0]);
        #1;
        reg_wr = 1'b0; reg_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 5'h08, 32'h0, 1'b0);
    endtask

    task automatic do_reset(input logic [2:0] sel, input int st, input int md);
        rst = 1'b1; clk_sel = sel;
        @(posedge clk); @(posedge clk); #1;
        rst = 1'b0;
        m_cnt = 0; m_acc = 0; m_as = st; m_am = md; m_ps = st; m_pm = md; m_commit = 0;
    endtask

    task automatic rd_reg(input logic [4:0] a, output logic [31:0] v);
        reg_addr = a; #1; v = reg_rdata;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        longint c0;

        // R1 R2 R3: table walk from reset
        for (int k = 0; k < 8; k++) begin
            do_reset(VEC[k][42:40], int'(VEC[k][23:12]), int'(VEC[k][11:0]));
            check("R1 count after reset", count_o, 64'd0);
            rd_reg(5'h10, v); check("R1 step readback", {32'h0, v}, {52'h0, VEC[k][23:12]});
            rd_reg(5'h14, v); check("R1 modulus readback", {32'h0, v}, {52'h0, VEC[k][11:0]});
            idle(RUN_N);
            check("R2 R3 count after run", count_o, {48'h0, VEC[k][39:24]});
        end

        // directed tests start from code 5 (768/3250)
        do_reset(3'd5, 768, 3250);
        idle(7);

        // R5 R6: pending step write keeps upper bits, no rate effect
        cyc(1'b1, 5'h10, 32'hABC0_0100, 1'b0);
        rd_reg(5'h10, v); check("R5 step upper bits", {32'h0, v}, 64'h0000_0000_ABC0_0100);
        idle(50);
        check("R6 rate unchanged before commit", count_o, 64'(m_cnt));

        // R7 R8: commit of 256/512 with upper modulus bits
        cyc(1'b1, 5'h14, 32'h5A01_0200, 1'b0);
        rd_reg(5'h14, v); check("R8 commit bit pending", {32'h0, v}, 64'h5A01_0200);
        cyc(1'b0, 5'h08, 32'h0, 1'b0);
        rd_reg(5'h14, v); check("R8 commit bit cleared", {32'h0, v}, 64'h5A00_0200);
        for (int i = 0; i < 12; i++) begin
            cyc(1'b0, 5'h08, 32'h0, 1'b0);
            check("R7 edge-by-edge after commit", count_o, 64'(m_cnt));
        end

        // R4: step equal to modulus counts every edge
        cyc(1'b1, 5'h10, 32'h0000_0200, 1'b0);
        cyc(1'b1, 5'h14, 32'h0001_0200, 1'b0);
        idle(2);
        c0 = longint'(count_o);
        idle(10);
        check("R4 full rate", count_o, 64'(c0 + 10));
        check("R4 model match", count_o, 64'(m_cnt));

        // R3: zero modulus holds the count
        cyc(1'b1, 5'h14, 32'h0001_0000, 1'b0);
        idle(2);
        c0 = longint'(count_o);
        idle(20);
        check("R3 hold on zero modulus", count_o, 64'(c0));

        // R9: 1/3 ratio, writes to count offsets and select change ignored
        cyc(1'b1, 5'h10, 32'h0000_0001, 1'b0);
        cyc(1'b1, 5'h14, 32'h0001_0003, 1'b0);
        cyc(1'b1, 5'h00, 32'hFFFF_FFFF, 1'b0);
        cyc(1'b1, 5'h04, 32'hFFFF_FFFF, 1'b0);
        clk_sel = 3'd0;
        idle(30);
        check("R9 accesses and select ignored", count_o, 64'(m_cnt));

        // R10: read port
        reg_addr = 5'h00; #1;
        check("R10 low word live", {32'h0, reg_rdata}, {32'h0, count_o[31:0]});
        cyc(1'b0, 5'h00, 32'h0, 1'b1);
        rd_reg(5'h04, v); check("R10 captured high word", {32'h0, v}, 64'h0);
        rd_reg(5'h08, v); check("R10 unused offset", {32'h0, v}, 64'h0);
        rd_reg(5'h00, v); check("R10 low word vs model", {32'h0, v}, {32'h0, 32'(m_cnt)});

        // R1: reset mid-run with another code
        do_reset(3'd7, 520, 3250);
        check("R1 count cleared mid-run", count_o, 64'd0);
        rd_reg(5'h10, v); check("R1 step reloaded", {32'h0, v}, 64'd520);
        idle(25);
        check("R2 code 7 short run", count_o, 64'd4);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule